// File: doc/BRIEF.md
# Banked Register Window Decoder

This block sits between a host bus and the control registers of a larger peripheral. The host sees only sixteen byte addresses. Those addresses reach four banks of registers, so the peripheral can hold far more registers than the window has addresses. One word of the window, the bank selector, stays in place whichever bank is active. The value written to it chooses which bank the other fourteen byte addresses reach. Bank 2 is the bank used for normal run-time traffic, so software usually parks the window there.

The host bus is synchronous. It carries a byte address, 16-bit write data, two byte-lane enables and separate read and write strobes. For an access to any word other than the selector, the block raises exactly one register select line, chosen by the active bank and the word offset. It passes the strobes, lanes and write data through to the registers in the same cycle. It then returns the selected register's value on the read data port one cycle later. A read of the selector returns an identification byte in its upper half and the bank number in its low bits.

Top module: `bankwin_window`

## Requirements
- R1: After reset the active bank is 0, `rdata_o` is 0 and no select line is raised.
- R2: The word at byte offsets 14/15 (word index 7) is the bank selector in every bank, and an access to it raises no register select line and no downstream strobe.
- R3: A write to the selector with `be_i[0]` set loads `wdata_i[1:0]` as the bank number, effective from the next cycle.
- R4: A read of the selector returns 0x33 in bits 15:8, zero in bits 7:2 and the bank number in bits 1:0 on `rdata_o` one cycle after `rd_i`.
- R5: A write to the selector with `be_i[0]` clear (upper lane only) leaves the bank number unchanged.
- R6: For word indices 0 to 6 with `rd_i` or `wr_i` high, exactly one bit of `sel_o` is high, at index bank*7 + word (word = `addr_i[3:1]`), in the same cycle; otherwise `sel_o` is 0.
- R7: A read of word index 0 to 6 returns on `rdata_o` one cycle later the 16-bit slice `reg_rdata_i[idx*16 +: 16]` of the register selected in the read cycle.
- R8: For word indices 0 to 6, `reg_wr_o`/`reg_rd_o` follow `wr_i`/`rd_i`, and `reg_be_o` and `reg_wdata_o` follow `be_i` and `wdata_i`, in the same cycle.
- R9: `rdata_o` keeps its value in every cycle that follows a cycle without `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Host byte address within the window |
| wdata_i | input | 16 | Host write data |
| be_i | input | 2 | Byte-lane enables (bit 0 = low byte) |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_i` |
| sel_o | output | 28 | One-hot register select, index bank*7 + word |
| reg_wr_o | output | 1 | Write strobe to the selected register |
| reg_rd_o | output | 1 | Read strobe to the selected register |
| reg_be_o | output | 2 | Byte enables to the selected register |
| reg_wdata_o | output | 16 | Write data to the selected register |
| reg_rdata_i | input | 448 | Register values, 16 bits per select index |

## Verification
The select lines and downstream strobes are combinational, so they are due in the same cycle as the host access. The bench checks them shortly after it drives the inputs at the falling edge. Read data passes through one register, so it is due one cycle after the read. The bench checks it at the following falling edge against a value the reference model stored at the rising edge. A bank change made by a selector write takes effect at that rising edge. The model therefore computes the read value from the bank as it stood before the edge and applies the new bank only from the next access onward.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
  localparam int unsigned ADDR_W_DEF    = 4;
  localparam int unsigned DATA_W_DEF    = 16;
  localparam int unsigned NUM_BANKS_DEF = 4;
  localparam logic [7:0]  ID_BYTE_DEF   = 8'h33;

  function automatic int unsigned flat_idx(int unsigned bank, int unsigned word,
                                           int unsigned regs_per_bank);
    return bank * regs_per_bank + word;
  endfunction
endpackage

// File: rtl/bankwin_bank_reg.sv
module bankwin_bank_reg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BANK_W  = 2,
  parameter logic [7:0]  ID_BYTE = 8'h33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              wr_i,
  input  logic              lo_be_i,
  input  logic [BANK_W-1:0] wbank_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [DATA_W-1:0] rd_val_o
);
  logic [BANK_W-1:0] bank_q;

  // only the low lane carries the bank number; upper lane is read-only id
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      bank_q <= '0;
    else if (hit_i && wr_i && lo_be_i) bank_q <= wbank_i;
  end

  always_comb begin
    rd_val_o                 = '0;
    rd_val_o[DATA_W-1 -: 8]  = ID_BYTE;
    rd_val_o[BANK_W-1:0]     = bank_q;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/bankwin_decode.sv
module bankwin_decode #(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned BANK_W        = 2,
  parameter int unsigned WORD_W        = 3,
  parameter int unsigned REGS_PER_BANK = 7,
  localparam int unsigned NUM_REGS     = NUM_BANKS * REGS_PER_BANK
) (
  input  logic                access_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit = access_i && (bank_i == BANK_W'(b));
    for (genvar w = 0; w < REGS_PER_BANK; w++) begin : g_word
      assign sel_o[bankwin_pkg::flat_idx(b, w, REGS_PER_BANK)] =
        bank_hit && (word_i == WORD_W'(w));
    end
  end
endmodule

// File: rtl/bankwin_rdmux.sv
module bankwin_rdmux #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 28
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic                       bank_hit_i,
  input  logic [DATA_W-1:0]          bank_val_i,
  input  logic [NUM_REGS-1:0]        sel_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [DATA_W-1:0] mux_val;
  logic [DATA_W-1:0] rdata_q;

  // AND-OR mux on the one-hot select
  always_comb begin
    mux_val = '0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      mux_val |= regs_i[i*DATA_W +: DATA_W] & {DATA_W{sel_i[i]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= bank_hit_i ? bank_val_i : mux_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bankwin_window.sv
module bankwin_window #(
  parameter int unsigned ADDR_W    = bankwin_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W    = bankwin_pkg::DATA_W_DEF,
  parameter int unsigned NUM_BANKS = bankwin_pkg::NUM_BANKS_DEF,
  parameter logic [7:0]  ID_BYTE   = bankwin_pkg::ID_BYTE_DEF,
  localparam int unsigned BE_W          = DATA_W / 8,
  localparam int unsigned WORD_W        = ADDR_W - 1,
  localparam int unsigned WORDS         = 2 ** WORD_W,
  localparam int unsigned REGS_PER_BANK = WORDS - 1,
  localparam int unsigned BANK_W        = $clog2(NUM_BANKS),
  localparam int unsigned NUM_REGS      = NUM_BANKS * REGS_PER_BANK
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [BE_W-1:0]            be_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS-1:0]        sel_o,
  output logic                       reg_wr_o,
  output logic                       reg_rd_o,
  output logic [BE_W-1:0]            reg_be_o,
  output logic [DATA_W-1:0]          reg_wdata_o,
  input  logic [NUM_REGS*DATA_W-1:0] reg_rdata_i
);
  localparam logic [WORD_W-1:0] BANK_WORD = WORD_W'(WORDS - 1);

  logic [WORD_W-1:0] word;
  logic              bank_hit;
  logic              reg_access;
  logic [BANK_W-1:0] bank_sel;
  logic [DATA_W-1:0] bank_val;
  logic              addr_lane_unused;

  assign word             = addr_i[ADDR_W-1:1];
  assign addr_lane_unused = addr_i[0];  // lanes come from be_i
  assign bank_hit         = (word == BANK_WORD);
  assign reg_access       = (rd_i || wr_i) && !bank_hit;

  bankwin_bank_reg #(
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .ID_BYTE(ID_BYTE)
  ) u_bank_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (bank_hit),
    .wr_i    (wr_i),
    .lo_be_i (be_i[0]),
    .wbank_i (wdata_i[BANK_W-1:0]),
    .bank_o  (bank_sel),
    .rd_val_o(bank_val)
  );

  bankwin_decode #(
    .NUM_BANKS    (NUM_BANKS),
    .BANK_W       (BANK_W),
    .WORD_W       (WORD_W),
    .REGS_PER_BANK(REGS_PER_BANK)
  ) u_decode (
    .access_i(reg_access),
    .bank_i  (bank_sel),
    .word_i  (word),
    .sel_o   (sel_o)
  );

  bankwin_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_rdmux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .bank_hit_i(bank_hit),
    .bank_val_i(bank_val),
    .sel_i     (sel_o),
    .regs_i    (reg_rdata_i),
    .rdata_o   (rdata_o)
  );

  assign reg_wr_o    = wr_i && !bank_hit;
  assign reg_rd_o    = rd_i && !bank_hit;
  assign reg_be_o    = be_i;
  assign reg_wdata_o = wdata_i;
endmodule

// File: rtl/bankwin_window_chk.sv
module bankwin_window_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_BANKS = 4,
  parameter logic [7:0]  ID_BYTE   = 8'h33,
  localparam int unsigned BE_W          = DATA_W / 8,
  localparam int unsigned WORD_W        = ADDR_W - 1,
  localparam int unsigned REGS_PER_BANK = (2 ** WORD_W) - 1,
  localparam int unsigned BANK_W        = $clog2(NUM_BANKS),
  localparam int unsigned NUM_REGS      = NUM_BANKS * REGS_PER_BANK
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [BE_W-1:0]     be_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_REGS-1:0] sel_o,
  input logic                reg_wr_o,
  input logic [BANK_W-1:0]   bank_sel
);
  logic              sel_word;
  logic [WORD_W-1:0] word;
  assign word     = addr_i[ADDR_W-1:1];
  assign sel_word = (word == WORD_W'(REGS_PER_BANK));

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R6

  AST_SEL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !sel_word) |->
      sel_o[int'(bank_sel) * int'(REGS_PER_BANK) + int'(word)]); // R6

  AST_SELECTOR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_word |-> (sel_o == '0 && !reg_wr_o)); // R2

  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_word && be_i[0]) |=> bank_sel == $past(wdata_i[BANK_W-1:0])); // R3

  AST_UPPER_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_word && !be_i[0]) |=> $stable(bank_sel)); // R5

  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_word) |=> rdata_o[DATA_W-1 -: 8] == ID_BYTE); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R9
endmodule

bind bankwin_window bankwin_window_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_BANKS(NUM_BANKS),
  .ID_BYTE  (ID_BYTE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .be_i    (be_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .sel_o   (sel_o),
  .reg_wr_o(reg_wr_o),
  .bank_sel(bank_sel)
);

// File: tb/bankwin_window_test.sv
module bankwin_window_test;
  localparam int NREG = 28;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        addr_i = '0;
  logic [15:0]       wdata_i = '0;
  logic [1:0]        be_i = '0;
  logic              wr_i = 1'b0;
  logic              rd_i = 1'b0;
  logic [15:0]       rdata_o;
  logic [NREG-1:0]   sel_o;
  logic              reg_wr_o;
  logic              reg_rd_o;
  logic [1:0]        reg_be_o;
  logic [15:0]       reg_wdata_o;
  logic [NREG*16-1:0] reg_rdata_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int          m_bank = 0;
  logic [15:0] m_rdata = '0;

  always #10 clk_i = ~clk_i;

  bankwin_window uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .be_i(be_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .sel_o(sel_o),
    .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_be_o(reg_be_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  function automatic logic [15:0] regval(int idx);
    return 16'((32'h5A00 ^ (idx * 32'h0123)) & 32'hFFFF);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(logic [3:0] a, logic [15:0] d, logic [1:0] be, bit w, bit r);
    int word;
    logic [NREG-1:0] exp_sel;
    @(negedge clk_i);
    check(rdata_o == m_rdata, "R7/R4/R9 rdata", 32'(rdata_o), 32'(m_rdata));
    addr_i = a; wdata_i = d; be_i = be; wr_i = w; rd_i = r;
    word = int'(a) / 2;
    exp_sel = '0;
    if ((w || r) && word != 7) exp_sel[m_bank * 7 + word] = 1'b1;
    #1;
    check(sel_o == exp_sel, (word == 7) ? "R2 sel" : "R6 sel", 32'(sel_o), 32'(exp_sel));
    check(reg_wr_o == (w && word != 7) && reg_rd_o == (r && word != 7),
          "R8/R2 strobes", {30'd0, reg_wr_o, reg_rd_o},
          {30'd0, (w && word != 7), (r && word != 7)});
    check(reg_be_o == be && reg_wdata_o == d, "R8 pass", {14'd0, reg_be_o, reg_wdata_o},
          {14'd0, be, d});
    @(posedge clk_i);
    if (r) m_rdata = (word == 7) ? {8'h33, 6'd0, 2'(m_bank)} : regval(m_bank * 7 + word);
    if (w && word == 7 && be[0]) m_bank = int'(d[1:0]);
  endtask

  task automatic idle();
    op(4'd0, 16'h0, 2'b00, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) reg_rdata_i[i*16 +: 16] = regval(i);
    #45;
    check(rdata_o == 16'h0 && sel_o == '0, "R1 reset", {rdata_o, 16'd0}, 32'd0);
    rst_ni = 1'b1;
    // R1: bank 0 after reset, read through selector
    op(4'd14, 16'h0, 2'b11, 1'b0, 1'b1);
    idle();
    // R7: every word of bank 0
    for (int wd = 0; wd < 7; wd++) op(4'(wd * 2), 16'h0, 2'b11, 1'b0, 1'b1);
    // R3: switch to bank 2 (run-time bank)
    op(4'd14, 16'h0002, 2'b01, 1'b1, 1'b0);
    for (int wd = 0; wd < 7; wd++) op(4'(wd * 2), 16'h0, 2'b11, 1'b0, 1'b1);
    // R5: upper-lane-only write to offset 15 keeps the bank
    op(4'd15, 16'hFF03, 2'b10, 1'b1, 1'b0);
    op(4'd14, 16'h0, 2'b11, 1'b0, 1'b1);
    // R4: all-ones write, bits 7:2 read zero
    op(4'd14, 16'hFFFF, 2'b11, 1'b1, 1'b0);
    op(4'd14, 16'h0, 2'b11, 1'b0, 1'b1);
    // R8: register writes in bank 3
    for (int wd = 0; wd < 7; wd++) op(4'(wd * 2 + 1), 16'(16'hA0 + wd), 2'b10, 1'b1, 1'b0);
    // R2: selector reachable from every bank; R6 per bank
    for (int b = 0; b < 4; b++) begin
      op(4'd14, 16'(b), 2'b01, 1'b1, 1'b0);
      for (int wd = 0; wd < 7; wd++) op(4'(wd * 2), 16'h0, 2'b01, 1'b0, 1'b1);
      op(4'd14, 16'h0, 2'b11, 1'b0, 1'b1);
    end
    // R3: read in the same cycle-window as a bank change uses old bank
    op(4'd4, 16'h0, 2'b11, 1'b0, 1'b1);
    op(4'd14, 16'h0001, 2'b01, 1'b1, 1'b0);
    op(4'd4, 16'h0, 2'b11, 1'b0, 1'b1);
    // R9: idle cycles hold rdata
    repeat (4) idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule